// File: doc/BRIEF.md
# Edge-Timing Clock Recovery and Equalizer Adaptation Engine

This block is the digital update logic behind a bang-bang clock recovery loop and a four-tap decision feedback equalizer. On every accepted cycle it takes one recovered data decision and the transition sample taken just before that decision. From the samples at the leading and trailing edges of each eye it derives two kinds of information. When both edges lean the same way, the block issues a one-cycle phase command to the interpolator. When they lean opposite ways, the eye is too narrow or too wide, and that sign drives a sign-sign LMS update of the equalizer taps.

A transition sample counts as early when it equals the decision before its crossing and as late when it equals the decision after it. It is used only when those two decisions differ. The eye of decision d[n-1] is bounded by the edge between d[n-2] and d[n-1] (leading) and the edge between d[n-1] and d[n] (trailing). The block judges that eye in the cycle in which d[n] arrives. Each tap step does not reach the tap directly: it goes into a per-tap accumulator that acts as a low-pass filter. The applied tap moves by one LSB only when the accumulated sum reaches a programmable threshold.

Top module: `cdr_dfe_adapt`

## Requirements
- R1: When the eye has both edges valid and both early, `phase_ret` is high for exactly the cycle after the input that completed the eye.
- R2: When the eye has both edges valid and both late, `phase_adv` is high for exactly the cycle after the input that completed the eye.
- R3: An edge whose neighbouring decisions are equal is ignored. An eye with such an edge issues no phase command and changes no accumulator or tap.
- R4: A leading-early/trailing-late eye is under-equalized (error +1). A leading-late/trailing-early eye is over-equalized (error -1). For tap k (k = 1..4), the accumulator then moves by `step_size` times the error sign times the sign of d[n-1-k], where a decision of 1 counts as +1 and 0 as -1. This takes effect two cycles after the completing input.
- R5: If an accumulator update leaves a positive value at or above `lpf_thresh`, the tap rises by one LSB. If it leaves a negative value whose magnitude is at or above `lpf_thresh`, the tap falls by one LSB. In either case the accumulator clears; otherwise it keeps the new value.
- R6: Taps saturate with no wrap-around. Tap 1 spans 0..31 (unsigned, `taps_o[4:0]`). Tap 2 spans -15..15 (two's complement, `taps_o[9:5]`). Taps 3 and 4 span -7..7 (two's complement, `taps_o[13:10]` and `taps_o[17:14]`).
- R7: No eye is judged until five valid decisions have been accepted. A cycle with `in_vld` low changes no history and issues no phase command or tap step.
- R8: After reset both phase commands are low and all taps read zero.
- R9: `phase_adv` and `phase_ret` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | The decision and edge sample this cycle are valid |
| in_data | input | 1 | Recovered data decision |
| in_edge | input | 1 | Transition sample taken between the previous decision and this one |
| step_size | input | 8 | LMS step added to or subtracted from each accumulator |
| lpf_thresh | input | 8 | Accumulator magnitude that moves a tap by one LSB |
| phase_adv | output | 1 | Advance the sampling phase |
| phase_ret | output | 1 | Delay the sampling phase |
| taps_o | output | 18 | Four packed tap coefficients (fields as in R6) |

## Verification
The hardest condition to reach from the ports is a tap pinned at both of its limits. That needs hundreds of consistently signed error steps, which random data with random edges almost never produces. The stimulus sets a zero threshold and sends an alternating data pattern whose edge samples alternate between early and late. Under-equalized and over-equalized eyes then alternate, and so do the history signs, so every tap is pushed the same way on every eye. Swapping the edge phase drives each tap to the opposite limit. A behavioural model tracks every tap, accumulator and command on each clock and is compared against the outputs throughout this and the random phases.

// File: rtl/cdr_dfe_pkg.sv
package cdr_dfe_pkg;
    localparam int NTAPS   = 4;
    localparam int HIST_W  = NTAPS + 1;
    localparam int STEP_W  = 8;
    localparam int ACC_W   = STEP_W + 2;
    localparam int FILL_W  = $clog2(HIST_W + 1);

    function automatic int tap_w(input int k);
        return (k < 2) ? 5 : 4;
    endfunction

    function automatic int tap_lo(input int k);
        return (k == 0) ? 0 : -((1 << (tap_w(k) - 1)) - 1);
    endfunction

    function automatic int tap_hi(input int k);
        return (k == 0) ? (1 << tap_w(k)) - 1 : (1 << (tap_w(k) - 1)) - 1;
    endfunction

    function automatic int tap_off(input int k);
        int s;
        s = 0;
        for (int i = 0; i < k; i++) s += tap_w(i);
        return s;
    endfunction

    localparam int TAPS_BITS = tap_off(NTAPS);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              edge_prev;
        logic [FILL_W-1:0] fill;
        logic              adv;
        logic              ret;
        logic              upd;
        logic              under;
        logic [NTAPS-1:0]  sgn;
    } eval_t;
endpackage

// File: rtl/cdr_edge_eval.sv
module cdr_edge_eval
    import cdr_dfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             din_i,
    input  logic             ein_i,
    output logic             adv_o,
    output logic             ret_o,
    output logic             upd_o,
    output logic             under_o,
    output logic [NTAPS-1:0] sgn_o
);
    eval_t st_d, st_q;
    logic  judge, lead_ok, trail_ok, lead_early, trail_early;

    always_comb begin
        st_d        = st_q;
        st_d.adv    = 1'b0;
        st_d.ret    = 1'b0;
        st_d.upd    = 1'b0;
        judge       = vld_i && (st_q.fill == FILL_W'(HIST_W));
        lead_ok     = st_q.hist[1] != st_q.hist[0];
        trail_ok    = st_q.hist[0] != din_i;
        lead_early  = st_q.edge_prev == st_q.hist[1];
        trail_early = ein_i == st_q.hist[0];
        if (judge && lead_ok && trail_ok) begin
            st_d.adv   = !lead_early && !trail_early;
            st_d.ret   = lead_early && trail_early;
            st_d.upd   = lead_early != trail_early;
            st_d.under = lead_early;
            st_d.sgn   = st_q.hist[NTAPS:1];
        end
        if (vld_i) begin
            st_d.hist      = {st_q.hist[HIST_W-2:0], din_i};
            st_d.edge_prev = ein_i;
            if (st_q.fill != FILL_W'(HIST_W)) st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign adv_o   = st_q.adv;
    assign ret_o   = st_q.ret;
    assign upd_o   = st_q.upd;
    assign under_o = st_q.under;
    assign sgn_o   = st_q.sgn;

    assert_no_dual_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.adv && st_q.ret));
    assert_act_needs_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.adv || st_q.ret || st_q.upd) |-> $past(vld_i));
    assert_flat_edge_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.adv || st_q.ret || st_q.upd) |-> ($past(din_i) != $past(st_q.hist[0])));
endmodule

// File: rtl/cdr_tap_adapt.sv
module cdr_tap_adapt
    import cdr_dfe_pkg::*;
#(
    parameter int W  = 5,
    parameter int LO = -15,
    parameter int HI = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              up_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [STEP_W-1:0] thr_i,
    output logic [W-1:0]      tap_o
);
    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [W-1:0]            tap;
    } tap_state_t;

    tap_state_t st_d, st_q;
    int cur, nxt_acc, thr;

    always_comb begin
        st_d    = st_q;
        cur     = (LO < 0) ? int'($signed(st_q.tap)) : int'($unsigned(st_q.tap));
        thr     = int'($unsigned(thr_i));
        nxt_acc = int'(st_q.acc) + (up_i ? int'($unsigned(step_i)) : -int'($unsigned(step_i)));
        if (upd_i) begin
            if (nxt_acc > 0 && nxt_acc >= thr) begin
                st_d.acc = '0;
                if (cur < HI) st_d.tap = W'(cur + 1);
            end else if (nxt_acc < 0 && -nxt_acc >= thr) begin
                st_d.acc = '0;
                if (cur > LO) st_d.tap = W'(cur - 1);
            end else begin
                st_d.acc = ACC_W'(nxt_acc);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_o = st_q.tap;

    assert_tap_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur >= LO) && (cur <= HI));
    assert_single_lsb_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tap != $past(st_q.tap)) |->
            ($past(upd_i) && ((st_q.tap == $past(st_q.tap) + W'(1)) ||
                              (st_q.tap == $past(st_q.tap) - W'(1)))));
endmodule

// File: rtl/cdr_dfe_adapt.sv
module cdr_dfe_adapt
    import cdr_dfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_data,
    input  logic                 in_edge,
    input  logic [STEP_W-1:0]    step_size,
    input  logic [STEP_W-1:0]    lpf_thresh,
    output logic                 phase_adv,
    output logic                 phase_ret,
    output logic [TAPS_BITS-1:0] taps_o
);
    logic             upd, under;
    logic [NTAPS-1:0] sgn;

    cdr_edge_eval u_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (in_vld),
        .din_i   (in_data),
        .ein_i   (in_edge),
        .adv_o   (phase_adv),
        .ret_o   (phase_ret),
        .upd_o   (upd),
        .under_o (under),
        .sgn_o   (sgn)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        logic up_k;
        assign up_k = (under == sgn[k]);
        cdr_tap_adapt #(
            .W  (tap_w(k)),
            .LO (tap_lo(k)),
            .HI (tap_hi(k))
        ) u_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd_i  (upd),
            .up_i   (up_k),
            .step_i (step_size),
            .thr_i  (lpf_thresh),
            .tap_o  (taps_o[tap_off(k) +: tap_w(k)])
        );
    end
endmodule

// File: tb/cdr_dfe_adapt_tb.sv
module cdr_dfe_adapt_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0, in_data = 1'b0, in_edge = 1'b0;
    logic [7:0] step_size = 8'd1, lpf_thresh = 8'd0;
    logic       phase_adv, phase_ret;
    logic [17:0] taps_o;

    cdr_dfe_adapt u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .in_edge(in_edge), .step_size(step_size), .lpf_thresh(lpf_thresh),
        .phase_adv(phase_adv), .phase_ret(phase_ret), .taps_o(taps_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nfail = 0;
    bit done = 0;
    string tag = "R8";

    int mh[5];
    int mep = 0, mfill = 0;
    int madv = 0, mret = 0, mupd = 0, munder = 0;
    int msgn[4];
    int macc[4];
    int mtap[4];
    int lo[4] = '{0, -15, -7, -7};
    int hi[4] = '{31, 15, 7, 7};
    int lastd = 0;

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int tap_val(input int k);
        case (k)
            0: return int'(taps_o[4:0]);
            1: return int'($signed(taps_o[9:5]));
            2: return int'($signed(taps_o[13:10]));
            default: return int'($signed(taps_o[17:14]));
        endcase
    endfunction

    task automatic compare();
        chk("phase_adv (R2)", int'(phase_adv), madv);
        chk("phase_ret (R1)", int'(phase_ret), mret);
        chk("exclusive commands R9", int'(phase_adv && phase_ret), 0);
        for (int k = 0; k < 4; k++)
            chk($sformatf("tap%0d (R4 R5 R6)", k + 1), tap_val(k), mtap[k]);
    endtask

    task automatic model(input int v, input int d, input int e);
        int mu, th, a, le, te;
        mu = int'(step_size);
        th = int'(lpf_thresh);
        if (mupd != 0) begin
            for (int k = 0; k < 4; k++) begin
                a = macc[k] + ((munder == msgn[k]) ? mu : -mu);
                if (a > 0 && a >= th) begin
                    macc[k] = 0;
                    if (mtap[k] < hi[k]) mtap[k]++;
                end else if (a < 0 && -a >= th) begin
                    macc[k] = 0;
                    if (mtap[k] > lo[k]) mtap[k]--;
                end else macc[k] = a;
            end
        end
        madv = 0; mret = 0; mupd = 0;
        if (v != 0 && mfill >= 5 && mh[1] != mh[0] && mh[0] != d) begin
            le = (mep == mh[1]);
            te = (e == mh[0]);
            if (le != 0 && te != 0) mret = 1;
            else if (le == 0 && te == 0) madv = 1;
            else begin
                mupd = 1;
                munder = le;
                for (int k = 0; k < 4; k++) msgn[k] = mh[k + 1];
            end
        end
        if (v != 0) begin
            for (int i = 4; i > 0; i--) mh[i] = mh[i - 1];
            mh[0] = d;
            mep = e;
            if (mfill < 5) mfill++;
        end
    endtask

    task automatic step(input int v, input int d, input int e);
        in_vld  = v[0];
        in_data = d[0];
        in_edge = e[0];
        model(v, d, e);
        if (v != 0) lastd = d;
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (CLK_PERIOD / 1ns * 200000) #1ns;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int d;
        for (int i = 0; i < 5; i++) mh[i] = 0;
        for (int k = 0; k < 4; k++) begin
            msgn[k] = 0; macc[k] = 0; mtap[k] = 0;
        end
        repeat (3) @(negedge clk);
        tag = "R8";
        compare();
        rst_n = 1'b1;

        // R7: history fill and idle cycles
        tag = "R7";
        for (int i = 0; i < 5; i++) begin
            d = 1 - lastd;
            step(1, d, lastd);
            chk("no command before history full R7", int'(phase_ret), 0);
        end
        for (int i = 0; i < 6; i++) step(0, i % 2, 1 - (i % 2));
        chk("idle cycles quiet R7", int'(phase_ret || phase_adv), 0);

        // R1: both edges early
        tag = "R1";
        for (int i = 0; i < 20; i++) begin
            d = 1 - lastd;
            step(1, d, lastd);
            chk("retard pulse R1", int'(phase_ret), 1);
        end

        // R2: both edges late
        tag = "R2";
        d = 1 - lastd; step(1, d, d);
        for (int i = 0; i < 20; i++) begin
            d = 1 - lastd;
            step(1, d, d);
            chk("advance pulse R2", int'(phase_adv), 1);
        end

        // R3: flat data, edges meaningless
        tag = "R3";
        step(1, lastd, 0);
        step(1, lastd, 1);
        for (int i = 0; i < 20; i++) begin
            step(1, lastd, int'($urandom_range(0, 1)));
            chk("flat data no command R3", int'(phase_adv || phase_ret), 0);
        end

        // R6: drive taps to both limits
        tag = "R6";
        step_size = 8'd1; lpf_thresh = 8'd0;
        for (int i = 0; i < 120; i++) begin
            d = 1 - lastd;
            step(1, d, (i % 2 == 0) ? lastd : d);
        end
        chk("tap1 at limit R6", tap_val(0) == 0 || tap_val(0) == 31, 1);
        chk("tap2 at limit R6", tap_val(1) == 15 || tap_val(1) == -15, 1);
        for (int i = 0; i < 120; i++) begin
            d = 1 - lastd;
            step(1, d, (i % 2 == 1) ? lastd : d);
        end
        chk("tap3 at limit R6", tap_val(2) == 7 || tap_val(2) == -7, 1);
        chk("tap4 at limit R6", tap_val(3) == 7 || tap_val(3) == -7, 1);

        // R4 R5: random traffic with filtering
        tag = "R4_R5";
        for (int blk = 0; blk < 10; blk++) begin
            step_size  = 8'($urandom_range(1, 6));
            lpf_thresh = 8'($urandom_range(0, 24));
            for (int i = 0; i < 120; i++)
                step(($urandom_range(0, 7) != 0) ? 1 : 0,
                     int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule